// File: doc/BRIEF.md
# Biphase-mark digital audio transmitter

This block turns stereo sample pairs into a self-clocking serial audio line in the consumer/professional digital audio style (IEC-60958 / AES-3 framing). Each frame holds two subframes: left goes in the even one and right in the odd one. Seen from the sample side, the block works like a two-slot TDM port. It latches a left and right word for every lane once per frame and announces that moment with a one-cycle `pair_take` strobe.

Every subframe is 32 slots, sent as 64 half-cells. One half-cell is sent per clock, so `clk` runs at twice the bit rate. The slots are, in order:

- a 4-slot preamble;
- 24 audio bits, sent LSB first;
- validity, user and channel-status bits;
- an even-parity bit.

The user and channel-status bits come from two 384-entry bit stores. The stores are indexed by the position of the frame within a 192-frame block. Each lane (`LANES` parameter) carries its own audio. All lanes share the clock, the validity bits and the store contents.

A two-state controller paces each subframe:

- `ST_PREAMBLE` covers half-cells 0 to 7. It moves to `ST_PAYLOAD` on half-cell 7.
- `ST_PAYLOAD` covers half-cells 8 to 63. It returns to `ST_PREAMBLE` on half-cell 63, where the subframe side flips. After a right subframe, the frame number also advances and wraps from 191 back to 0.

Top module: `bmc_audio_tx`

## Requirements
- R1: While `rst_n` is low every `line_out` bit is 0. The first frame sent after reset is frame 0 of a block, and its capture happens at the first clock edge after release.
- R2: Biphase-mark coding: the line level changes at the start of every slot from slot 4 onwards. It changes again in the middle of a slot exactly when that slot's bit is 1.
- R3: A subframe is 64 half-cells, one per clock. Slots 4..27 carry audio bit 0..23, slot 28 carries validity, slot 29 user, slot 30 channel status and slot 31 parity. Left and right subframes alternate, left first.
- R4: Half-cells 0..7 hold a preamble, written first-sent bit leftmost and valid when the previous half-cell was 0: 11101000 on the left subframe of frame 0, 11100010 on the other left subframes, 11100100 on right subframes. All 8 half-cells are inverted when the previous half-cell was 1.
- R5: The parity bit makes the count of ones in slots 4..31 even.
- R6: `valid_l` and `valid_r`, captured with the sample pair, set the validity bit of the left and right subframe respectively.
- R7: Two 384-bit stores are written one bit per cycle through `st_we`, `st_sel` (0 = channel status, 1 = user), `st_addr` and `st_din`. Frame f sends store bit 2f on its left subframe and 2f+1 on its right. Each bit is read at the clock edge that starts its subframe, so a write landing on that same edge is seen only on a later read.
- R8: The 24-bit audio field is bits [4a+23:4a] of the lane's input word, where a = `align_sel`. Bits above the word are read as 0.
- R9: `pair_take` is high for one cycle before each frame. At the following edge every lane's left and right words, `align_sel` and both validity inputs are captured. Later input changes do not affect that frame.
- R10: All lanes send identical preamble, validity, user and channel-status content. Only the audio field differs between lanes.
- R11: The frame number counts 0..191 and wraps to 0, so the block preamble recurs every 192 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock (twice the bit rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| left_in | input | LANES*WORD_W | Left sample word per lane |
| right_in | input | LANES*WORD_W | Right sample word per lane |
| align_sel | input | 2 | Nibble offset of the audio field in the input word |
| valid_l | input | 1 | Validity bit for left subframes |
| valid_r | input | 1 | Validity bit for right subframes |
| st_we | input | 1 | Store write enable |
| st_sel | input | 1 | Store select: 0 channel status, 1 user |
| st_addr | input | ADDR_W | Store bit address (0..383) |
| st_din | input | 1 | Store write bit |
| pair_take | output | 1 | Sample pair is captured at the next edge |
| line_out | output | LANES | Encoded output line per lane |

## Verification
A store write and the store read that starts a subframe can land on the same clock edge. The bench provokes this by writing the channel-status bit of the current left subframe in the cycle `pair_take` is high. It expects the old bit on the line and the new bit one block later. A second write, issued inside the left subframe to the address of the right subframe that follows, must show up in that right subframe. A mid-frame change of the sample words and validity inputs is checked against the same capture edge: it must be invisible until the next frame.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
    localparam int AUD_W     = 24;
    localparam int PRE_SLOTS = 4;
    localparam int HALF_N    = 64;
    localparam int PRE_HALF  = 2 * PRE_SLOTS;
    localparam int HC_W      = $clog2(HALF_N);
    localparam int SLOT_W    = HC_W - 1;

    localparam logic [SLOT_W-1:0] SLOT_V = SLOT_W'(PRE_SLOTS + AUD_W);
    localparam logic [SLOT_W-1:0] SLOT_U = SLOT_W'(PRE_SLOTS + AUD_W + 1);
    localparam logic [SLOT_W-1:0] SLOT_C = SLOT_W'(PRE_SLOTS + AUD_W + 2);
    localparam logic [SLOT_W-1:0] SLOT_P = SLOT_W'(PRE_SLOTS + AUD_W + 3);

    localparam logic [PRE_HALF-1:0] PAT_BLOCK = 8'b1110_1000;
    localparam logic [PRE_HALF-1:0] PAT_LEFT  = 8'b1110_0010;
    localparam logic [PRE_HALF-1:0] PAT_RIGHT = 8'b1110_0100;

    typedef enum logic {ST_PREAMBLE, ST_PAYLOAD} tx_state_t;
    typedef enum logic [1:0] {PK_BLOCK, PK_LEFT, PK_RIGHT} pre_kind_t;
endpackage

// File: rtl/bmc_seq_ctl.sv
module bmc_seq_ctl
    import bmc_tx_pkg::*;
#(
    parameter int FRAMES = 192,
    localparam int FR_W = $clog2(FRAMES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_l,
    input  logic                valid_r,
    output logic [HC_W-1:0]     hc,
    output logic                odd,
    output logic [FR_W-1:0]     frame,
    output logic                in_pre,
    output logic                pair_load,
    output logic                sub_load,
    output logic [PRE_HALF-1:0] pre_pat,
    output logic                v_bit
);
    tx_state_t       state_q, state_d;
    logic [HC_W-1:0] hc_q;
    logic            odd_q;
    logic [FR_W-1:0] frame_q;
    logic            v_q, vr_q;
    logic            last_half, last_pre;
    pre_kind_t       kind;

    assign last_half = (hc_q == HC_W'(HALF_N - 1));
    assign last_pre  = (hc_q == HC_W'(PRE_HALF - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PREAMBLE;
        else        state_q <= state_d;
    end

    // next state and decoded strobes
    always_comb begin
        state_d   = state_q;
        in_pre    = 1'b0;
        sub_load  = 1'b0;
        pair_load = 1'b0;
        unique case (state_q)
            ST_PREAMBLE: begin
                in_pre    = 1'b1;
                sub_load  = (hc_q == '0);
                pair_load = (hc_q == '0) && !odd_q;
                if (last_pre) state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (last_half) state_d = ST_PREAMBLE;
            end
            default: state_d = ST_PREAMBLE;
        endcase
    end

    // half-cell, side and frame position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q    <= '0;
            odd_q   <= 1'b0;
            frame_q <= '0;
        end else begin
            hc_q <= hc_q + 1'b1;
            if (last_half) begin
                odd_q <= !odd_q;
                if (odd_q) frame_q <= (frame_q == FR_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
            end
        end
    end

    // validity: both captured with the pair, right one held for the odd subframe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= 1'b0;
            vr_q <= 1'b0;
        end else if (pair_load) begin
            v_q  <= valid_l;
            vr_q <= valid_r;
        end else if (sub_load) begin
            v_q  <= vr_q;
        end
    end

    always_comb begin
        if (odd_q)               kind = PK_RIGHT;
        else if (frame_q == '0)  kind = PK_BLOCK;
        else                     kind = PK_LEFT;
        unique case (kind)
            PK_BLOCK: pre_pat = PAT_BLOCK;
            PK_LEFT:  pre_pat = PAT_LEFT;
            PK_RIGHT: pre_pat = PAT_RIGHT;
            default:  pre_pat = PAT_RIGHT;
        endcase
    end

    assign hc    = hc_q;
    assign odd   = odd_q;
    assign frame = frame_q;
    assign v_bit = v_q;
endmodule

// File: rtl/bmc_bit_store.sv
module bmc_bit_store #(
    parameter int DEPTH = 384,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);
    logic [DEPTH-1:0] mem;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem   <= '0;
            rdata <= 1'b0;
        end else begin
            if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
            if (re && (32'(raddr) < DEPTH)) rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/bmc_lane_enc.sv
module bmc_lane_enc
    import bmc_tx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WORD_W-1:0]   left_w,
    input  logic [WORD_W-1:0]   right_w,
    input  logic [1:0]          align_sel,
    input  logic                pair_load,
    input  logic                sub_load,
    input  logic                in_pre,
    input  logic [HC_W-1:0]     hc,
    input  logic [PRE_HALF-1:0] pre_pat,
    input  logic                v_bit,
    input  logic                u_bit,
    input  logic                c_bit,
    output logic                line
);
    logic [AUD_W-1:0]  cur_q, rhold_q;
    logic [AUD_W-1:0]  aud_l, aud_r;
    logic [WORD_W-1:0] sh_l, sh_r;
    logic              par_q, inv_q, inv, bit_val;
    logic [SLOT_W-1:0] slot, aidx;
    logic [2:0]        pidx;

    assign sh_l  = left_w  >> {align_sel, 2'b00};
    assign sh_r  = right_w >> {align_sel, 2'b00};
    assign aud_l = sh_l[AUD_W-1:0];
    assign aud_r = sh_r[AUD_W-1:0];

    assign slot = hc[HC_W-1:1];
    assign aidx = slot - SLOT_W'(PRE_SLOTS);
    assign pidx = 3'(PRE_HALF - 1) - hc[2:0];
    assign inv  = (hc == '0) ? line : inv_q;

    always_comb begin
        if (slot == SLOT_V)      bit_val = v_bit;
        else if (slot == SLOT_U) bit_val = u_bit;
        else if (slot == SLOT_C) bit_val = c_bit;
        else if (slot == SLOT_P) bit_val = par_q;
        else if (32'(aidx) < AUD_W) bit_val = cur_q[aidx];
        else                     bit_val = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            rhold_q <= '0;
        end else if (pair_load) begin
            cur_q   <= aud_l;
            rhold_q <= aud_r;
        end else if (sub_load) begin
            cur_q   <= rhold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line  <= 1'b0;
            par_q <= 1'b0;
            inv_q <= 1'b0;
        end else if (in_pre) begin
            line  <= pre_pat[pidx] ^ inv;
            par_q <= 1'b0;
            if (hc == '0) inv_q <= line;
        end else if (!hc[0]) begin
            line <= !line;
            if (slot != SLOT_P) par_q <= par_q ^ bit_val;
        end else begin
            line <= bit_val ? !line : line;
        end
    end
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
    import bmc_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANES  = 2,
    parameter int FRAMES = 192,
    localparam int DEPTH  = 2 * FRAMES,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int FR_W   = $clog2(FRAMES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*WORD_W-1:0] left_in,
    input  logic [LANES*WORD_W-1:0] right_in,
    input  logic [1:0]              align_sel,
    input  logic                    valid_l,
    input  logic                    valid_r,
    input  logic                    st_we,
    input  logic                    st_sel,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic                    st_din,
    output logic                    pair_take,
    output logic [LANES-1:0]        line_out
);
    logic [HC_W-1:0]     hc;
    logic                odd, in_pre, pair_load, sub_load, v_bit, u_bit, c_bit;
    logic [FR_W-1:0]     frame;
    logic [PRE_HALF-1:0] pre_pat;
    logic [ADDR_W-1:0]   rd_addr;

    assign rd_addr   = {frame, odd};
    assign pair_take = pair_load;

    bmc_seq_ctl #(.FRAMES(FRAMES)) i_ctl (
        .clk(clk), .rst_n(rst_n), .valid_l(valid_l), .valid_r(valid_r),
        .hc(hc), .odd(odd), .frame(frame), .in_pre(in_pre),
        .pair_load(pair_load), .sub_load(sub_load), .pre_pat(pre_pat), .v_bit(v_bit)
    );

    bmc_bit_store #(.DEPTH(DEPTH)) i_cstat (
        .clk(clk), .rst_n(rst_n), .we(st_we && !st_sel), .waddr(st_addr), .wdata(st_din),
        .re(sub_load), .raddr(rd_addr), .rdata(c_bit)
    );

    bmc_bit_store #(.DEPTH(DEPTH)) i_udata (
        .clk(clk), .rst_n(rst_n), .we(st_we && st_sel), .waddr(st_addr), .wdata(st_din),
        .re(sub_load), .raddr(rd_addr), .rdata(u_bit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        bmc_lane_enc #(.WORD_W(WORD_W)) i_enc (
            .clk(clk), .rst_n(rst_n),
            .left_w(left_in[g*WORD_W +: WORD_W]), .right_w(right_in[g*WORD_W +: WORD_W]),
            .align_sel(align_sel), .pair_load(pair_load), .sub_load(sub_load),
            .in_pre(in_pre), .hc(hc), .pre_pat(pre_pat),
            .v_bit(v_bit), .u_bit(u_bit), .c_bit(c_bit), .line(line_out[g])
        );
    end
endmodule

// File: rtl/bmc_audio_tx_chk.sv
module bmc_audio_tx_chk #(
    parameter int FRAMES = 192,
    localparam int FR_W = $clog2(FRAMES)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [5:0]      hc,
    input logic            odd,
    input logic [FR_W-1:0] frame,
    input logic            line0,
    input logic            pair_take
);
    p_cell_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hc >= 6'd9 && hc[0]) |-> (line0 != $past(line0)));

    p_pre_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hc == 6'd1) |-> (line0 != $past(line0)));

    p_side_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hc == 6'd63) |=> (odd != $past(odd)));

    p_take_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_take |=> !pair_take);

    p_block_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hc == 6'd63 && odd && frame == FR_W'(FRAMES - 1)) |=> (frame == '0));
endmodule

bind bmc_audio_tx bmc_audio_tx_chk #(.FRAMES(FRAMES)) i_chk (
    .clk(clk), .rst_n(rst_n), .hc(hc), .odd(odd), .frame(frame),
    .line0(line_out[0]), .pair_take(pair_take)
);

// File: tb/test_bmc_audio_tx.sv
module test_bmc_audio_tx;
    localparam int WORD_W = 32;
    localparam int LANES  = 2;
    localparam int FRAMES = 192;
    localparam int ADDR_W = 9;
    localparam logic [7:0] PB = 8'b1110_1000, PM = 8'b1110_0010, PW = 8'b1110_0100;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic [LANES*WORD_W-1:0] left_in = '0, right_in = '0;
    logic [1:0] align_sel = 2'd0;
    logic valid_l = 1'b0, valid_r = 1'b0;
    logic st_we = 1'b0, st_sel = 1'b0, st_din = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic pair_take;
    logic [LANES-1:0] line_out;

    bmc_audio_tx #(.WORD_W(WORD_W), .LANES(LANES), .FRAMES(FRAMES)) i_bmc_audio_tx (
        .clk(clk), .rst_n(rst_n), .left_in(left_in), .right_in(right_in),
        .align_sel(align_sel), .valid_l(valid_l), .valid_r(valid_r),
        .st_we(st_we), .st_sel(st_sel), .st_addr(st_addr), .st_din(st_din),
        .pair_take(pair_take), .line_out(line_out)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    bit cs_m [2*FRAMES];
    bit u_m  [2*FRAMES];
    bit [127:0] hcap [LANES];
    bit [LANES-1:0] gprev;
    int  col_at = -2;
    bit  col_sel, col_val;
    int  col_addr;
    int  mid_at = -1;
    logic [LANES*WORD_W-1:0] mid_l, mid_r;

    always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int cur_frame();
        return (cyc / 128) % FRAMES;
    endfunction

    task automatic wait_take(int target);
        while (!(pair_take && cur_frame() == target)) @(negedge clk);
    endtask

    task automatic write_bit(bit sel, int addr, bit val);
        @(negedge clk);
        st_we = 1; st_sel = sel; st_addr = ADDR_W'(addr); st_din = val;
        @(negedge clk);
        st_we = 0;
        if (sel) u_m[addr] = val; else cs_m[addr] = val;
    endtask

    // called at the negedge where pair_take is high; records the next frame
    task automatic grab();
        for (int l = 0; l < LANES; l++) gprev[l] = line_out[l];
        for (int i = 0; i < 128; i++) begin
            if (i == col_at + 1) begin
                st_we = 1; st_sel = col_sel; st_addr = ADDR_W'(col_addr); st_din = col_val;
            end
            if (i == mid_at) begin
                left_in = mid_l; right_in = mid_r; valid_l = !valid_l; valid_r = !valid_r;
            end
            @(negedge clk);
            if (i == col_at + 2) begin
                st_we = 0;
                if (col_sel) u_m[col_addr] = col_val; else cs_m[col_addr] = col_val;
            end
            for (int l = 0; l < LANES; l++) hcap[l][i] = line_out[l];
        end
        col_at = -2; mid_at = -1;
    endtask

    task automatic check_sub(int ln, int side, int f, logic [31:0] w, int al,
                             bit v, bit u, bit c, string tag);
        bit h [64];
        bit prev, ok, last;
        logic [7:0] pre, epre;
        logic [31:0] bits;
        logic [23:0] ea, da;
        string rq;
        for (int i = 0; i < 64; i++) h[i] = hcap[ln][side*64 + i];
        prev = side ? hcap[ln][63] : gprev[ln];
        for (int i = 0; i < 8; i++) pre[7-i] = h[i];
        epre = (side ? PW : (f == 0 ? PB : PM)) ^ {8{prev}};
        chk(pre === epre, (f == 0 && side == 0) ? "R4/R11" : "R4", {tag, " preamble"}, pre, epre);
        ok = 1; last = h[7]; bits = '0;
        for (int s = 4; s < 32; s++) begin
            if (h[2*s] == last) ok = 0;
            bits[s] = h[2*s] != h[2*s+1];
            last = h[2*s+1];
        end
        chk(ok, "R2", {tag, " cell boundary toggles"}, ok, 1);
        ea = 24'(w >> (4*al));
        da = bits[27:4];
        chk(da === ea, "R3/R8", {tag, " audio field"}, da, ea);
        rq = (ln > 0) ? "R10" : "R6";
        chk(bits[28] == v, rq, {tag, " validity"}, bits[28], v);
        rq = (ln > 0) ? "R10" : "R7";
        chk(bits[29] == u, rq, {tag, " user bit"}, bits[29], u);
        chk(bits[30] == c, rq, {tag, " channel status"}, bits[30], c);
        chk(^bits[31:4] == 1'b0, "R5", {tag, " even parity"}, bits[31], ^bits[30:4]);
    endtask

    task automatic check_frame(int f, logic [LANES*WORD_W-1:0] lw, logic [LANES*WORD_W-1:0] rw,
                               int al, bit vl, bit vr, bit cl, bit cr, bit ul, bit ur, string tag);
        for (int l = 0; l < LANES; l++) begin
            check_sub(l, 0, f, lw[l*WORD_W +: WORD_W], al, vl, ul, cl, $sformatf("%s lane%0d left", tag, l));
            check_sub(l, 1, f, rw[l*WORD_W +: WORD_W], al, vr, ur, cr, $sformatf("%s lane%0d right", tag, l));
        end
    endtask

    task automatic run_frame(int f, logic [LANES*WORD_W-1:0] lw, logic [LANES*WORD_W-1:0] rw,
                             int al, bit vl, bit vr, string tag);
        bit cl, cr, ul, ur;
        wait_take(f);
        left_in = lw; right_in = rw; align_sel = 2'(al); valid_l = vl; valid_r = vr;
        cl = cs_m[2*f]; cr = cs_m[2*f+1]; ul = u_m[2*f]; ur = u_m[2*f+1];
        grab();
        if (col_sel) ur = u_m[2*f+1]; else cr = cs_m[2*f+1];
        check_frame(f, lw, rw, al, vl, vr, cl, cr, ul, ur, tag);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(line_out === '0, "R1", "line low in reset", line_out, 0);
        rst_n = 1;
        chk(pair_take === 1'b1 && cur_frame() == 0, "R1", "first capture right after release", pair_take, 1);
    endtask

    task automatic t_basic();
        run_frame(0, {32'h00C3_A5F1, 32'h0012_3456}, {32'h00FF_FFFF, 32'h0080_0001}, 0, 0, 1, "basic f0");
        run_frame(1, {32'h0000_0000, 32'h00AA_AAAA}, {32'h0055_5555, 32'h0000_0000}, 0, 1, 0, "basic f1");
    endtask

    task automatic t_align();
        run_frame(2, {32'hABCD_EF12, 32'h1234_5678}, {32'h8765_4321, 32'hF0F0_F0F0}, 1, 1, 1, "align1");
        run_frame(3, {32'hABCD_EF12, 32'hFEDC_BA98}, {32'h8765_4321, 32'h0F0F_0F0F}, 2, 0, 0, "align2");
        run_frame(4, {32'hABCD_EF12, 32'hFEDC_BA98}, {32'h8765_4321, 32'h0F0F_0F0F}, 3, 0, 1, "align3 zero fill");
    endtask

    task automatic t_store();
        write_bit(0, 12, 1); write_bit(0, 13, 0); write_bit(1, 12, 0); write_bit(1, 13, 1);
        write_bit(0, 14, 0); write_bit(0, 15, 1); write_bit(1, 14, 1); write_bit(1, 15, 1);
        run_frame(6, {32'h0010_0000, 32'h0000_0007}, {32'h0000_0100, 32'h0070_0000}, 0, 0, 0, "store R7 f6");
        run_frame(7, {32'h0010_0000, 32'h0000_0007}, {32'h0000_0100, 32'h0070_0000}, 0, 1, 0, "store R7 f7");
    endtask

    task automatic t_hold();
        mid_at = 40;
        mid_l = {32'h0000_0000, 32'h00FF_0000};
        mid_r = {32'h0011_1111, 32'h0022_2222};
        run_frame(8, {32'h0012_3123, 32'h0045_6456}, {32'h0078_9789, 32'h00AB_CABC}, 0, 1, 0, "hold R9 f8");
        wait_take(9);
        grab();
        check_frame(9, mid_l, mid_r, 0, 0, 1, cs_m[18], cs_m[19], u_m[18], u_m[19], "hold R9 f9 new pair");
    endtask

    task automatic t_collide();
        col_at = -1; col_sel = 0; col_addr = 20; col_val = 1;
        run_frame(10, {32'h0000_0AAA, 32'h0000_0555}, {32'h0000_0333, 32'h0000_0CCC}, 0, 0, 0, "collide R7 f10");
        col_at = 10; col_sel = 1; col_addr = 23; col_val = 1;
        run_frame(11, {32'h0000_0AAA, 32'h0000_0555}, {32'h0000_0333, 32'h0000_0CCC}, 0, 0, 0, "mid write R7 f11");
    endtask

    task automatic t_wrap();
        run_frame(FRAMES-1, {32'h0000_1234, 32'h0000_4321}, {32'h0000_5678, 32'h0000_8765}, 0, 1, 1, "wrap R11 last");
        run_frame(0, {32'h00F0_0000, 32'h000F_0000}, {32'h0000_F000, 32'h0000_0F00}, 0, 0, 1, "wrap R11 first");
        run_frame(10, {32'h0000_0AAA, 32'h0000_0555}, {32'h0000_0333, 32'h0000_0CCC}, 0, 0, 0, "collide R7 later block");
    endtask

    initial begin
        col_sel = 0; col_val = 0; col_addr = 0; mid_l = '0; mid_r = '0;
        t_reset();
        t_basic();
        t_align();
        t_store();
        t_hold();
        t_collide();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule